// File: doc/BRIEF.md
# Peripheral Trigger Step Sequencer

This block steps through a small queue of 8-bit commands and uses them to coordinate other on-chip blocks with no processor involvement. A step can stall until a chosen hardware input reaches a chosen level. It can also idle for a programmed number of sequencer ticks, or emit a single pulse on one of sixteen trigger lines or sixteen interrupt lines. Jump and halt steps control the flow of the program. A watchdog guards every hardware wait. If the awaited level never shows up, the watchdog aborts the step, stops the sequencer and pulses a separate error interrupt.

A host port loads the queue and the configuration registers, and it starts, stops and clears the sequencer. The configuration registers hold the delay length, the pulse stretch, the tick divider and the watchdog limit. Every step, delay and pulse advances on the sequencer tick, which the divider derives from the input clock. Changing the divider therefore scales all timing at once.

Host map (`host_addr`): 0x00–0x0F are the queue slots (data bits 7:0). 0x10 is the delay limit, 0x11 the pulse stretch, 0x12 the tick divider and 0x13 the watchdog limit. 0x14 is control: bit 0 start, bit 1 stop, bit 2 clear error, bit 3 watchdog enable. The enable bit is stored on every write to control.

Top module: `tseq_top`

## Requirements
- R1: After reset, `busy`, `err_flag`, `wd_irq` and all trigger and interrupt lines are low.
- R2: A step byte holds the command code in bits 7:4 and the option in bits 3:0. Code 0x3 drives `trig_out[option]` and code 0x4 drives `irq_out[option]`, each for the length of that step.
- R3: A pulse step lasts (S+1) sequencer ticks, where S is the pulse-stretch register. With S=0 the pulse is one tick wide.
- R4: A sequencer tick occurs once every D+1 input clocks, where D is the divider register. The divider restarts on start, so with D=2 and S=2 a pulse is 9 clocks wide.
- R5: Code 0x2 holds the step pointer for L+1 ticks, where L is the delay register. This sets the gap between the pulses before and after it.
- R6: Code 0x1 waits on input `hw_evt[option bits 2:0]` for the level given by option bit 3 (1 = high, 0 = low). It completes on the first tick where the input shows that level.
- R7: With the watchdog enabled and limit W, a wait that sees no match on W+1 consecutive ticks is aborted on the last of them. The sequencer then stops, `err_flag` sets, and `wd_irq` pulses for one clock. A match on that last tick completes the step instead.
- R8: `err_flag` stays set and start requests are ignored until a clear is written. A later start then runs normally.
- R9: Code 0xE sets the pointer to twice the option, modulo 16. Code 0xF with option 0 halts, and `busy` falls after that tick. Code 0xF with another option, and any unassigned code, take one tick and advance. The pointer wraps from 15 to 0.
- R10: Queue writes are ignored while `busy` is high and take effect while stopped.
- R11: At most one of the 33 lines `trig_out`, `irq_out` and `wd_irq` is high in any clock.
- R12: A stop request drops `busy` and all pulse lines in the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register / queue slot address |
| host_wdata | input | CNT_W | Host write data |
| hw_evt | input | 8 | Hardware event inputs for wait steps |
| trig_out | output | 16 | Trigger pulses toward peripherals |
| irq_out | output | 16 | General interrupt pulses |
| wd_irq | output | 1 | Watchdog abort interrupt, one clock |
| busy | output | 1 | Sequencer running |
| err_flag | output | 1 | Sticky watchdog error |

## Verification
The bench builds the block with its default counter width of 16 bits. Because the delay, stretch, divider and watchdog limits are run-time registers, the bench programs them to small values: a divider of 2, a stretch of 2, a delay of 3 and a watchdog limit of 4. These keep every tick boundary, the watchdog's final-tick race and the pointer wrap within a few tens of clocks. The fixed 4-bit option field sets the 16-slot queue and the 8 event inputs, so every jump target and output line is reachable with the default build.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  localparam int OPT_W   = 4;
  localparam int CODE_W  = 4;
  localparam int STEP_W  = CODE_W + OPT_W;
  localparam int Q_AW    = OPT_W;
  localparam int Q_DEPTH = 1 << Q_AW;
  localparam int EVT_N   = 1 << (OPT_W - 1);
  localparam int OUT_N   = 1 << OPT_W;
  localparam int HADDR_W = Q_AW + 1;

  localparam logic [CODE_W-1:0] C_NOP   = 4'h0;
  localparam logic [CODE_W-1:0] C_WAIT  = 4'h1;
  localparam logic [CODE_W-1:0] C_DELAY = 4'h2;
  localparam logic [CODE_W-1:0] C_TRIG  = 4'h3;
  localparam logic [CODE_W-1:0] C_IRQ   = 4'h4;
  localparam logic [CODE_W-1:0] C_JUMP  = 4'hE;
  localparam logic [CODE_W-1:0] C_HALT  = 4'hF;

  localparam logic [HADDR_W-1:0] A_DELAY = 5'h10;
  localparam logic [HADDR_W-1:0] A_PW    = 5'h11;
  localparam logic [HADDR_W-1:0] A_DIV   = 5'h12;
  localparam logic [HADDR_W-1:0] A_WDLIM = 5'h13;
  localparam logic [HADDR_W-1:0] A_CTRL  = 5'h14;

  localparam int B_START = 0;
  localparam int B_STOP  = 1;
  localparam int B_CLR   = 2;
  localparam int B_WDEN  = 3;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [OPT_W-1:0]  opt;
  } step_t;

  typedef enum logic {S_IDLE, S_RUN} seq_state_e;

  // Jump destination: twice the option, folded into the queue range
  function automatic logic [Q_AW-1:0] jump_target(input logic [OPT_W-1:0] opt);
    logic [OPT_W:0] t;
    t = {opt, 1'b0};
    return t[Q_AW-1:0];
  endfunction

  // Wait condition: low option bits pick the input, top bit the level
  function automatic logic wait_met(input logic [EVT_N-1:0] evt,
                                    input logic [OPT_W-1:0] opt);
    return evt[opt[OPT_W-2:0]] == opt[OPT_W-1];
  endfunction

endpackage

// File: rtl/tseq_tick_div.sv
module tseq_tick_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] div_lim,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt >= div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_lim != '0) |=> (!tick || div_lim == '0));

endmodule

// File: rtl/tseq_step_queue.sv
module tseq_step_queue
  import tseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              lock,
  input  logic [Q_AW-1:0]   waddr,
  input  logic [STEP_W-1:0] wdata,
  input  logic [Q_AW-1:0]   raddr,
  output logic [STEP_W-1:0] rdata
);

  logic [STEP_W-1:0] mem [Q_DEPTH];
  logic              wr_ok;

  assign wr_ok = we && !lock;
  assign rdata = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < Q_DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/tseq_watchdog.sv
module tseq_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             arm,
  input  logic             step_end,
  input  logic             tick,
  input  logic             evt_met,
  input  logic [CNT_W-1:0] lim,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  assign expire = en && arm && tick && !evt_met && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!arm || step_end)  cnt <= '0;
    else if (tick && !expire)   cnt <= cnt + 1'b1;
  end

  // R7
  wd_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm) |-> (cnt == '0));

endmodule

// File: rtl/tseq_top.sv
module tseq_top
  import tseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [CNT_W-1:0]   host_wdata,
  input  logic [EVT_N-1:0]   hw_evt,
  output logic [OUT_N-1:0]   trig_out,
  output logic [OUT_N-1:0]   irq_out,
  output logic               wd_irq,
  output logic               busy,
  output logic               err_flag
);

  // host side
  logic             q_we, ctrl_wr;
  logic             start_req, stop_req, clr_req, start_ok;
  logic [CNT_W-1:0] delay_lim, pw_lim, div_lim, wd_lim;
  logic             wd_en;

  // sequencer side
  seq_state_e        state;
  logic [Q_AW-1:0]   cur_ptr, next_ptr;
  logic [CNT_W-1:0]  step_cnt;
  logic [STEP_W-1:0] q_rdata;
  step_t             cmd;
  logic              tick, step_done, halt_now, advance;
  logic              is_wait, evt_ok, wd_expire;

  assign q_we      = host_we && !host_addr[HADDR_W-1];
  assign ctrl_wr   = host_we && (host_addr == A_CTRL);
  assign start_req = ctrl_wr && host_wdata[B_START];
  assign stop_req  = ctrl_wr && host_wdata[B_STOP];
  assign clr_req   = ctrl_wr && host_wdata[B_CLR];
  assign busy      = (state == S_RUN);
  assign start_ok  = !busy && start_req && !err_flag && !stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_lim <= '0;
      pw_lim    <= '0;
      div_lim   <= '0;
      wd_lim    <= '0;
      wd_en     <= 1'b0;
    end else if (host_we) begin
      case (host_addr)
        A_DELAY: delay_lim <= host_wdata;
        A_PW:    pw_lim    <= host_wdata;
        A_DIV:   div_lim   <= host_wdata;
        A_WDLIM: wd_lim    <= host_wdata;
        A_CTRL:  wd_en     <= host_wdata[B_WDEN];
        default: ;
      endcase
    end
  end

  tseq_step_queue u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (q_we),
    .lock  (busy),
    .waddr (host_addr[Q_AW-1:0]),
    .wdata (host_wdata[STEP_W-1:0]),
    .raddr (cur_ptr),
    .rdata (q_rdata)
  );

  tseq_tick_div #(.CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_ok),
    .div_lim (div_lim),
    .tick    (tick)
  );

  assign cmd     = step_t'(q_rdata);
  assign evt_ok  = wait_met(hw_evt, cmd.opt);
  assign is_wait = busy && (cmd.code == C_WAIT);

  // Step completion and the pointer that follows it
  always_comb begin
    step_done = 1'b1;
    halt_now  = 1'b0;
    next_ptr  = cur_ptr + 1'b1;
    case (cmd.code)
      C_WAIT:        step_done = evt_ok;
      C_DELAY:       step_done = (step_cnt >= delay_lim);
      C_TRIG, C_IRQ: step_done = (step_cnt >= pw_lim);
      C_JUMP:        next_ptr  = jump_target(cmd.opt);
      C_HALT:        halt_now  = (cmd.opt == '0);
      default:       step_done = 1'b1;
    endcase
  end

  assign advance = busy && tick && step_done;

  tseq_watchdog #(.CNT_W(CNT_W)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (wd_en),
    .arm      (is_wait),
    .step_end (advance),
    .tick     (tick),
    .evt_met  (evt_ok),
    .lim      (wd_lim),
    .expire   (wd_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_ptr  <= '0;
      step_cnt <= '0;
      err_flag <= 1'b0;
      wd_irq   <= 1'b0;
    end else begin
      wd_irq <= wd_expire;
      if (wd_expire)    err_flag <= 1'b1;
      else if (clr_req) err_flag <= 1'b0;

      if (stop_req) begin
        state <= S_IDLE;
      end else if (!busy) begin
        if (start_ok) begin
          state    <= S_RUN;
          cur_ptr  <= '0;
          step_cnt <= '0;
        end
      end else if (wd_expire) begin
        state <= S_IDLE;
      end else if (advance) begin
        if (halt_now) state <= S_IDLE;
        else          cur_ptr <= next_ptr;
        step_cnt <= '0;
      end else if (tick) begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // One decoded line per output, live for the whole step
  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    assign trig_out[g] = busy && (cmd.code == C_TRIG) && (cmd.opt == OPT_W'(g));
    assign irq_out[g]  = busy && (cmd.code == C_IRQ)  && (cmd.opt == OPT_W'(g));
  end

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wd_irq, irq_out, trig_out}));

  // R7
  wd_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> (!busy && err_flag && wd_irq));

  // R8
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !busy) |=> !busy);

  // R12
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!busy && trig_out == '0 && irq_out == '0));

  // R9
  jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && cmd.code == C_JUMP && !stop_req)
      |=> (cur_ptr == jump_target($past(cmd.opt))));

endmodule

// File: tb/sim_tseq_top.sv
`timescale 1ns/1ps
module sim_tseq_top;

  localparam int CW = 16;
  localparam int NL = 33;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [4:0]    host_addr = '0;
  logic [CW-1:0] host_wdata = '0;
  logic [7:0]    hw_evt = '0;
  logic [15:0]   trig_out, irq_out;
  logic          wd_irq, busy, err_flag;

  tseq_top #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .hw_evt(hw_evt), .trig_out(trig_out),
    .irq_out(irq_out), .wd_irq(wd_irq), .busy(busy), .err_flag(err_flag));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, t0 = 0, last_wr = 0;
  bit overlap = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // pulse log: line 0..15 trig, 16..31 irq, 32 watchdog
  int ev_n = 0;
  int ev_line [64];
  int ev_start [64];
  int ev_w [64];
  int open_idx [NL];
  logic [NL-1:0] b_now, b_prev = '0;

  initial for (int i = 0; i < NL; i++) open_idx[i] = -1;

  always @(negedge clk) begin
    b_now = {wd_irq, irq_out, trig_out};
    if ($countones(b_now) > 1) overlap = 1;
    for (int i = 0; i < NL; i++) begin
      if (b_now[i] && !b_prev[i] && ev_n < 64) begin
        ev_line[ev_n] = i; ev_start[ev_n] = cyc; ev_w[ev_n] = 0;
        open_idx[i] = ev_n; ev_n++;
      end
      if (b_now[i] && open_idx[i] >= 0) ev_w[open_idx[i]]++;
    end
    b_prev = b_now;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic hwr(input logic [4:0] a, input int d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = CW'(d);
    @(negedge clk);
    host_we = 1'b0;
    last_wr = cyc;
  endtask

  task automatic start_seq(input bit wden);
    ev_n = 0;
    hwr(5'h14, wden ? 9 : 1);
    t0 = last_wr;
  endtask

  task automatic wait_rel(input int n);
    while (cyc < t0 + n) @(negedge clk);
    #1;
  endtask

  task automatic chk_ev(input int k, input int line, input int st, input int w, input string tag);
    chk(ev_n > k, {tag, " count"}, ev_n, k + 1);
    if (ev_n > k) begin
      chk(ev_line[k] == line, {tag, " line"}, ev_line[k], line);
      chk(ev_start[k] - t0 == st, {tag, " start"}, ev_start[k] - t0, st);
      chk(ev_w[k] == w, {tag, " width"}, ev_w[k], w);
    end
  endtask

  task automatic cfg(input int dly, input int pw, input int dv, input int wd);
    hwr(5'h10, dly); hwr(5'h11, pw); hwr(5'h12, dv); hwr(5'h13, wd);
  endtask

  task automatic t_reset();
    #1;
    chk(busy == 0 && err_flag == 0, "R1 busy/err", {busy, err_flag}, 0);
    chk(trig_out == 0 && irq_out == 0 && wd_irq == 0, "R1 lines", {wd_irq, irq_out, trig_out}, 0);
  endtask

  // R2 R5: trigger, delay, interrupt, halt
  task automatic t_basic();
    cfg(3, 0, 0, 0);
    hwr(5'h00, 'h35); hwr(5'h01, 'h20); hwr(5'h02, 'h4A); hwr(5'h03, 'hF0);
    start_seq(0);
    wait_rel(6);
    chk(busy == 1, "R9 busy before halt", busy, 1);
    wait_rel(7);
    chk(busy == 0, "R9 halt", busy, 0);
    chk(ev_n == 2, "R2 event count", ev_n, 2);
    chk_ev(0, 5, 0, 1, "R2 trig5");
    chk_ev(1, 26, 5, 1, "R5 irq10 after delay");
  endtask

  // R3 R4: stretch and divider
  task automatic t_width();
    cfg(0, 2, 2, 0);
    hwr(5'h00, 'h30); hwr(5'h01, 'h31); hwr(5'h02, 'hF0);
    start_seq(0);
    wait_rel(25);
    chk_ev(0, 0, 0, 9, "R3 R4 trig0");
    chk_ev(1, 1, 9, 9, "R3 R4 trig1");
    chk(busy == 0, "R4 halted", busy, 0);
    cfg(0, 0, 0, 0);
  endtask

  // R6: wait high then wait low
  task automatic t_wait();
    hw_evt = '0;
    hwr(5'h00, 'h1B); hwr(5'h01, 'h32); hwr(5'h02, 'h13);
    hwr(5'h03, 'h33); hwr(5'h04, 'hF0);
    start_seq(0);
    wait_rel(8);
    chk(ev_n == 0 && busy == 1, "R6 stalled", ev_n, 0);
    hw_evt[3] = 1'b1;
    wait_rel(15);
    hw_evt[3] = 1'b0;
    wait_rel(20);
    chk(ev_n == 2, "R6 event count", ev_n, 2);
    chk_ev(0, 2, 9, 1, "R6 high wait");
    chk_ev(1, 3, 16, 1, "R6 low wait");
    chk(busy == 0, "R6 halted", busy, 0);
  endtask

  // R7 R8: abort, sticky error, clear, last-tick match
  task automatic t_watchdog();
    cfg(0, 0, 0, 4);
    hw_evt = '0;
    hwr(5'h00, 'h1F); hwr(5'h01, 'h30); hwr(5'h02, 'hF0);
    start_seq(1);
    wait_rel(4);
    chk(busy == 1 && wd_irq == 0, "R7 still waiting", busy, 1);
    wait_rel(5);
    chk(busy == 0 && err_flag == 1, "R7 abort", {busy, err_flag}, 1);
    wait_rel(8);
    chk(ev_n == 1, "R7 only wd pulse", ev_n, 1);
    chk_ev(0, 32, 5, 1, "R7 wd_irq");
    start_seq(1);
    wait_rel(3);
    chk(busy == 0 && err_flag == 1, "R8 start ignored", {busy, err_flag}, 1);
    hwr(5'h14, 'hC);
    #1;
    chk(err_flag == 0, "R8 clear", err_flag, 0);
    start_seq(1);
    wait_rel(4);
    hw_evt[7] = 1'b1;
    wait_rel(9);
    chk(err_flag == 0, "R7 no abort on last tick", err_flag, 0);
    chk(ev_n == 1, "R7 boundary count", ev_n, 1);
    chk_ev(0, 0, 5, 1, "R7 R8 boundary trig0");
    hw_evt = '0;
    hwr(5'h14, 0);
  endtask

  // R9: jump, no-op forms, halt
  task automatic t_jump();
    hwr(5'h00, 'hE3); hwr(5'h06, 'h37); hwr(5'h07, 'hF5);
    hwr(5'h08, 'h50); hwr(5'h09, 'hF0);
    start_seq(0);
    wait_rel(4);
    chk(busy == 1, "R9 nops advance", busy, 1);
    wait_rel(5);
    chk(busy == 0, "R9 halt after nops", busy, 0);
    chk(ev_n == 1, "R9 count", ev_n, 1);
    chk_ev(0, 7, 1, 1, "R9 jump to 6");
  endtask

  // R9 R12: loop through wrap, then stop
  task automatic t_loop();
    hwr(5'h00, 'hE7); hwr(5'h0E, 'h3C); hwr(5'h0F, 'h00);
    start_seq(0);
    wait_rel(9);
    chk(ev_n == 3, "R9 loop count", ev_n, 3);
    chk_ev(0, 12, 1, 1, "R9 loop pass1");
    chk_ev(1, 12, 4, 1, "R9 wrap pass2");
    chk_ev(2, 12, 7, 1, "R9 wrap pass3");
    hwr(5'h14, 'h2);
    #1;
    chk(busy == 0, "R12 loop stopped", busy, 0);
  endtask

  // R12: stop in the middle of a long pulse
  task automatic t_stop();
    cfg(0, 50, 0, 0);
    hwr(5'h00, 'h30); hwr(5'h01, 'hF0);
    start_seq(0);
    wait_rel(5);
    chk(trig_out == 16'h0001, "R12 pulse live", trig_out, 1);
    hwr(5'h14, 'h2);
    #1;
    chk(busy == 0 && trig_out == 0, "R12 stop", {busy, trig_out}, 0);
    cfg(0, 0, 0, 0);
  endtask

  // R10: queue locked while running, open while stopped
  task automatic t_lock();
    hw_evt = '0;
    hwr(5'h00, 'h1B); hwr(5'h01, 'h31); hwr(5'h02, 'hF0);
    start_seq(0);
    hwr(5'h01, 'h38);
    wait_rel(5);
    hw_evt[3] = 1'b1;
    wait_rel(10);
    chk(ev_n == 1, "R10 count", ev_n, 1);
    chk_ev(0, 1, 6, 1, "R10 write ignored");
    hwr(5'h01, 'h38);
    start_seq(0);
    wait_rel(5);
    chk_ev(0, 8, 1, 1, "R10 write while stopped");
    hw_evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_width();
    t_wait();
    t_watchdog();
    t_jump();
    t_loop();
    t_stop();
    t_lock();
    chk(overlap == 0, "R11 one line at a time", overlap, 0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog timeout", cyc, 0);
    finish_run();
  end

endmodule